// File: doc/BRIEF.md
# Indexed-window interrupt routing register file

This block is the register front end of an interrupt routing unit. A bus master reaches its registers indirectly. It first writes an index into a select register, then reads or writes a 32-bit data window. The window leads to one of several places: an identification register, a read-only version register, an arbitration register that mirrors the identification value, or one 32-bit half of a 64-bit routing entry. There is one routing entry per interrupt pin.

The routing entries are held in flops and exposed in parallel on a table port, for the delivery logic that sits next to this block. Every accepted entry write is followed by a one-cycle update strobe that carries the entry number, so the delivery logic can re-evaluate that pin.

Bus accesses are single-cycle strobes and are accepted in every cycle. A small access state machine records what the last cycle did and drives the outputs from that record. The state machine has three states:
- `ST_IDLE` is entered after a cycle with no read and no accepted entry write.
- `ST_RDATA` is entered after any read and presents read data with `bus_rvalid`.
- `ST_UPDATE` is entered after an accepted entry write that came without a read, and raises `upd_pulse`.

Every state reaches every other state directly. The next state depends only on the current bus strobes.

Top module: `intc_window_regs`

## Requirements
- R1: After reset, the select register is 0, the identification value is 0, every entry equals `ENTRY_RST` (default 0x0000_0000_0001_0000), and `bus_rvalid` and `upd_pulse` are low.
- R2: Offset 0x00 of `bus_addr` is the select register. A write stores `bus_wdata[7:0]` and a read returns it zero-extended, whatever `bus_size` holds.
- R3: A window access (offset 0x10) with `bus_size` other than 4 has no effect. A read returns 0 and a write changes no register and raises no `upd_pulse`.
- R4: A word read of the window with select 0x00 (identification) or 0x02 (arbitration) returns the 4-bit identification value in bits 27:24, with all other bits 0.
- R5: A word read with select 0x01 returns 0x0017_0011. This is the code 0x11 ORed with (24−1) placed at bit 16. Word writes to select 0x01 or 0x02 change nothing.
- R6: A word write with select 0x00 stores only `bus_wdata[27:24]` as the identification value.
- R7: For select values 0x10 to 0x3F, the entry number is (select−0x10)/2. An even select reads or writes bits 31:0 of that entry and an odd select bits 63:32. A write leaves the other half and all other entries unchanged.
- R8: Select values 0x03 to 0x0F and 0x40 to 0xFF read as 0 through the window, and writes to them change nothing.
- R9: Each accepted entry write causes `upd_pulse` high for exactly the cycle after the write, with `upd_index` equal to the entry number. No other access raises it.
- R10: Read data appears on `bus_rdata` with `bus_rvalid` high in the cycle after `bus_rd`. Offsets other than 0x00 and 0x10 read as 0 and ignore writes.
- R11: When `bus_rd` and `bus_wr` are high together, the read is performed and the write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Low byte of the access address |
| bus_size | input | 3 | Access size in bytes (1, 2 or 4) |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, cycle after bus_rd |
| tbl_entries | output | PINS*64 | All routing entries, entry k at bits 64k+63:64k |
| upd_pulse | output | 1 | One-cycle strobe after an entry write |
| upd_index | output | 5 | Entry number of the last entry write |

## Verification
Entry writes use alternating even and odd selects on the first, a middle and the last entry, with distinct patterns in each half. This separates a swapped half and an entry-number offset error, and shows whether a write clobbers the other half. Select values on both sides of each range edge are used: 0x02/0x03, 0x0F/0x10 and 0x3F/0x40. These expose an off-by-one in the decode. Narrow window accesses, simultaneous read and write, and odd bus offsets are each followed by word reads and a table-port compare, so that an effect which should not exist would show up at the ports.

// File: rtl/intc_win_pkg.sv
package intc_win_pkg;

    typedef enum logic [2:0] {
        K_NONE,
        K_ID,
        K_VER,
        K_ARB,
        K_TBL
    } win_kind_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RDATA,
        ST_UPDATE
    } acc_state_t;

    localparam logic [2:0] SIZE_WORD = 3'd4;

endpackage

// File: rtl/intc_win_decode.sv
module intc_win_decode
    import intc_win_pkg::*;
#(
    parameter int SEL_W = 8,
    parameter int PINS = 24,
    parameter int IDX_W = $clog2(PINS),
    parameter logic [SEL_W-1:0] ID_IDX = 8'h00,
    parameter logic [SEL_W-1:0] VER_IDX = 8'h01,
    parameter logic [SEL_W-1:0] ARB_IDX = 8'h02,
    parameter logic [SEL_W-1:0] TBL_BASE = 8'h10
) (
    input  logic [SEL_W-1:0] sel,
    output win_kind_t        kind,
    output logic [IDX_W-1:0] idx,
    output logic             hi
);

    logic [SEL_W-1:0] off;

    always_comb begin
        off  = sel - TBL_BASE;
        kind = K_NONE;
        idx  = '0;
        hi   = 1'b0;
        if (sel == ID_IDX) begin
            kind = K_ID;
        end else if (sel == VER_IDX) begin
            kind = K_VER;
        end else if (sel == ARB_IDX) begin
            kind = K_ARB;
        end else if (sel >= TBL_BASE && int'(off[SEL_W-1:1]) < PINS) begin
            kind = K_TBL;
            idx  = off[IDX_W:1];
            hi   = off[0];
        end
    end

endmodule

// File: rtl/intc_win_table.sv
module intc_win_table #(
    parameter int PINS = 24,
    parameter int IDX_W = $clog2(PINS),
    parameter logic [63:0] ENTRY_RST = 64'h0000_0000_0001_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic              hi,
    input  logic [31:0]       wdata,
    output logic [31:0]       rword,
    output logic [PINS*64-1:0] entries
);

    logic [63:0] ent_q [PINS];

    for (genvar g = 0; g < PINS; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_q[g] <= ENTRY_RST;
            end else if (we && int'(idx) == g) begin
                if (hi) begin
                    ent_q[g][63:32] <= wdata;
                end else begin
                    ent_q[g][31:0] <= wdata;
                end
            end
        end

        assign entries[g*64 +: 64] = ent_q[g];

        // R7: an entry write leaves the other half untouched
        a_r7_other_half_kept: assert property (@(posedge clk) disable iff (!rst_n)
            (we && int'(idx) == g) |=>
                (hi ? $stable(ent_q[g][31:0]) : $stable(ent_q[g][63:32])));

        // R7: entries not addressed do not change
        a_r7_others_kept: assert property (@(posedge clk) disable iff (!rst_n)
            !(we && int'(idx) == g) |=> $stable(ent_q[g]));
    end

    always_comb begin
        rword = '0;
        if (int'(idx) < PINS) begin
            rword = hi ? ent_q[idx][63:32] : ent_q[idx][31:0];
        end
    end

endmodule

// File: rtl/intc_window_regs.sv
module intc_window_regs
    import intc_win_pkg::*;
#(
    parameter int PINS = 24,
    parameter int SEL_W = 8,
    parameter int ID_W = 4,
    parameter int ID_POS = 24,
    parameter int CNT_POS = 16,
    parameter logic [31:0] VER_CODE = 32'h0000_0011,
    parameter logic [7:0] SEL_OFS = 8'h00,
    parameter logic [7:0] WIN_OFS = 8'h10,
    parameter logic [SEL_W-1:0] TBL_BASE = 8'h10,
    parameter logic [63:0] ENTRY_RST = 64'h0000_0000_0001_0000,
    localparam int IDX_W = $clog2(PINS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [7:0]         bus_addr,
    input  logic [2:0]         bus_size,
    input  logic               bus_rd,
    input  logic               bus_wr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic               bus_rvalid,
    output logic [PINS*64-1:0] tbl_entries,
    output logic               upd_pulse,
    output logic [IDX_W-1:0]   upd_index
);

    localparam logic [SEL_W-1:0] ID_IDX  = 8'h00;
    localparam logic [SEL_W-1:0] VER_IDX = 8'h01;
    localparam logic [SEL_W-1:0] ARB_IDX = 8'h02;
    localparam logic [31:0] VER_WORD = VER_CODE | (32'(PINS - 1) << CNT_POS);

    acc_state_t        state_q, state_d;
    logic [SEL_W-1:0]  sel_q;
    logic [ID_W-1:0]   id_q;
    logic [31:0]       rdata_q;
    logic [IDX_W-1:0]  uidx_q;

    win_kind_t         kind;
    logic [IDX_W-1:0]  idx;
    logic              hi;
    logic [31:0]       tbl_rword;

    logic is_sel, is_win, is_word, do_wr, win_word, tbl_we, id_we;
    logic [31:0] rd_val;

    intc_win_decode #(
        .SEL_W(SEL_W), .PINS(PINS), .IDX_W(IDX_W),
        .ID_IDX(ID_IDX), .VER_IDX(VER_IDX), .ARB_IDX(ARB_IDX),
        .TBL_BASE(TBL_BASE)
    ) decode_i (
        .sel  (sel_q),
        .kind (kind),
        .idx  (idx),
        .hi   (hi)
    );

    intc_win_table #(
        .PINS(PINS), .IDX_W(IDX_W), .ENTRY_RST(ENTRY_RST)
    ) table_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (tbl_we),
        .idx     (idx),
        .hi      (hi),
        .wdata   (bus_wdata),
        .rword   (tbl_rword),
        .entries (tbl_entries)
    );

    // access qualification
    always_comb begin
        is_sel   = (bus_addr == SEL_OFS);
        is_win   = (bus_addr == WIN_OFS);
        is_word  = (bus_size == SIZE_WORD);
        do_wr    = bus_wr && !bus_rd;
        win_word = is_win && is_word;
        tbl_we   = do_wr && win_word && (kind == K_TBL);
        id_we    = do_wr && win_word && (kind == K_ID);
    end

    // read data selection
    always_comb begin
        rd_val = '0;
        if (is_sel) begin
            rd_val = 32'(sel_q);
        end else if (win_word) begin
            unique case (kind)
                K_ID, K_ARB: rd_val = 32'(id_q) << ID_POS;
                K_VER:       rd_val = VER_WORD;
                K_TBL:       rd_val = tbl_rword;
                K_NONE:      rd_val = '0;
                default:     rd_val = '0;
            endcase
        end
    end

    // next-state logic
    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE, ST_RDATA, ST_UPDATE: begin
                if (bus_rd) begin
                    state_d = ST_RDATA;
                end else if (tbl_we) begin
                    state_d = ST_UPDATE;
                end else begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // data registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q   <= '0;
            id_q    <= '0;
            rdata_q <= '0;
            uidx_q  <= '0;
        end else begin
            if (do_wr && is_sel) begin
                sel_q <= bus_wdata[SEL_W-1:0];
            end
            if (id_we) begin
                id_q <= bus_wdata[ID_POS +: ID_W];
            end
            if (bus_rd) begin
                rdata_q <= rd_val;
            end
            if (tbl_we) begin
                uidx_q <= idx;
            end
        end
    end

    // outputs
    always_comb begin
        bus_rvalid = (state_q == ST_RDATA);
        upd_pulse  = (state_q == ST_UPDATE);
        bus_rdata  = rdata_q;
        upd_index  = uidx_q;
    end

    // R9: a strobe only follows a qualified entry write
    a_r9_pulse_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        upd_pulse |-> $past(bus_wr && !bus_rd && is_win && is_word));

    // R3: a narrow window write raises no strobe
    a_r3_narrow_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_rd && is_win && !is_word) |=> !upd_pulse);

    // R8: out-of-range window write leaves the table unchanged
    a_r8_range_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && is_win && kind == K_NONE) |=> $stable(tbl_entries));

    // R11: a read in the same cycle suppresses the strobe
    a_r11_read_wins: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> (bus_rvalid && !upd_pulse));

    // R10: read data valid exactly in the cycle after a read strobe
    a_r10_rvalid_timing: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rvalid |-> $past(bus_rd));

    // R5: the version register never changes
    a_r5_version_const: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_rd && win_word && kind == K_VER) |-> (bus_rdata == VER_WORD));

endmodule

// File: tb/intc_window_regs_tb_top.sv
module intc_window_regs_tb_top;

    localparam int PINS = 24;
    localparam logic [63:0] RST_ENT = 64'h0000_0000_0001_0000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [7:0] bus_addr = '0;
    logic [2:0] bus_size = '0;
    logic bus_rd = 1'b0;
    logic bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic bus_rvalid;
    logic [PINS*64-1:0] tbl_entries;
    logic upd_pulse;
    logic [4:0] upd_index;

    int total = 0;
    int bad = 0;
    logic [63:0] exp_ent [PINS];
    logic [3:0] exp_id = '0;
    logic seen_pulse;
    logic [4:0] seen_idx;
    logic seen_rv;

    always #2 clk = ~clk;

    intc_window_regs dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_size(bus_size),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
        .tbl_entries(tbl_entries), .upd_pulse(upd_pulse), .upd_index(upd_index)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [2:0] sz, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_size = sz; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        seen_pulse = upd_pulse;
        seen_idx = upd_index;
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, input logic [2:0] sz, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_size = sz; bus_rd = 1'b1;
        @(negedge clk);
        seen_rv = bus_rvalid;
        d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic win_read(input logic [7:0] s, output logic [31:0] d);
        bus_write(8'h00, 3'd4, {24'h0, s});
        bus_read(8'h10, 3'd4, d);
    endtask

    task automatic chk_table(input string req);
        for (int k = 0; k < PINS; k++) begin
            chk(req, tbl_entries[k*64 +: 64], exp_ent[k]);
        end
    endtask

    task automatic t_reset;
        logic [31:0] d;
        chk("R1 rvalid", {63'h0, bus_rvalid}, 64'h0);
        chk("R1 pulse", {63'h0, upd_pulse}, 64'h0);
        chk_table("R1 entries");
        bus_read(8'h00, 3'd4, d);
        chk("R1 select", {32'h0, d}, 64'h0);
        bus_read(8'h10, 3'd4, d);
        chk("R1 id", {32'h0, d}, 64'h0);
    endtask

    task automatic t_select;
        logic [31:0] d;
        bus_write(8'h00, 3'd1, 32'hABCD_EF5A);
        bus_read(8'h00, 3'd2, d);
        chk("R2 narrow select readback", {32'h0, d}, 64'h5A);
        chk("R10 rvalid", {63'h0, seen_rv}, 64'h1);
        @(negedge clk);
        chk("R10 rvalid drops", {63'h0, bus_rvalid}, 64'h0);
    endtask

    task automatic t_id_ver;
        logic [31:0] d;
        bus_write(8'h00, 3'd4, 32'h0);
        bus_write(8'h10, 3'd4, 32'hFFFF_FFFF);
        exp_id = 4'hF;
        bus_read(8'h10, 3'd4, d);
        chk("R6 id masked", {32'h0, d}, 64'h0F00_0000);
        chk("R9 no pulse on id write", {63'h0, seen_pulse}, 64'h0);
        bus_write(8'h10, 3'd4, 32'h0500_0000);
        exp_id = 4'h5;
        win_read(8'h02, d);
        chk("R4 arb alias", {32'h0, d}, 64'h0500_0000);
        win_read(8'h01, d);
        chk("R5 version", {32'h0, d}, 64'h0017_0011);
        bus_write(8'h10, 3'd4, 32'h0A00_0000);
        win_read(8'h01, d);
        chk("R5 version write ignored", {32'h0, d}, 64'h0017_0011);
        bus_write(8'h00, 3'd4, 32'h02);
        bus_write(8'h10, 3'd4, 32'h0C00_0000);
        win_read(8'h00, d);
        chk("R5 arb write ignored", {32'h0, d}, 64'h0500_0000);
    endtask

    task automatic t_table;
        logic [31:0] d;
        int ents[3] = '{0, 11, 23};
        for (int j = 0; j < 3; j++) begin
            int e = ents[j];
            logic [31:0] lo = 32'h1000_0000 + 32'(e) * 32'h0101;
            logic [31:0] hv = 32'hC000_0000 + 32'(e) * 32'h0202;
            bus_write(8'h00, 3'd4, 32'h10 + 32'(2*e));
            bus_write(8'h10, 3'd4, lo);
            exp_ent[e][31:0] = lo;
            chk("R9 pulse low", {63'h0, seen_pulse}, 64'h1);
            chk("R9 index low", {59'h0, seen_idx}, 64'(e));
            chk_table("R7 low half");
            bus_write(8'h00, 3'd4, 32'h11 + 32'(2*e));
            bus_write(8'h10, 3'd4, hv);
            exp_ent[e][63:32] = hv;
            chk("R9 index high", {59'h0, seen_idx}, 64'(e));
            chk_table("R7 high half");
            @(negedge clk);
            chk("R9 pulse one cycle", {63'h0, upd_pulse}, 64'h0);
            win_read(8'h10 + 8'(2*e), d);
            chk("R7 read low", {32'h0, d}, {32'h0, lo});
            win_read(8'h11 + 8'(2*e), d);
            chk("R7 read high", {32'h0, d}, {32'h0, hv});
        end
    endtask

    task automatic t_narrow;
        logic [31:0] d;
        bus_write(8'h00, 3'd4, 32'h26);
        bus_write(8'h10, 3'd2, 32'hDEAD_BEEF);
        chk("R3 narrow write no pulse", {63'h0, seen_pulse}, 64'h0);
        chk_table("R3 narrow write no change");
        bus_read(8'h10, 3'd2, d);
        chk("R3 narrow read zero", {32'h0, d}, 64'h0);
        bus_read(8'h10, 3'd4, d);
        chk("R3 word read still intact", {32'h0, d}, {32'h0, exp_ent[11][31:0]});
    endtask

    task automatic t_range;
        logic [31:0] d;
        logic [7:0] sels[4] = '{8'h03, 8'h0F, 8'h40, 8'hFF};
        for (int j = 0; j < 4; j++) begin
            bus_write(8'h00, 3'd4, {24'h0, sels[j]});
            bus_write(8'h10, 3'd4, 32'h5555_AAAA);
            chk("R8 no pulse", {63'h0, seen_pulse}, 64'h0);
            bus_read(8'h10, 3'd4, d);
            chk("R8 reads zero", {32'h0, d}, 64'h0);
        end
        chk_table("R8 table unchanged");
        win_read(8'h3F, d);
        chk("R8 edge 0x3F in range", {32'h0, d}, {32'h0, exp_ent[23][63:32]});
        win_read(8'h00, d);
        chk("R8 id unchanged", {32'h0, d}, {32'h0, exp_id, 24'h0});
    endtask

    task automatic t_decode;
        logic [31:0] d;
        bus_write(8'h00, 3'd4, 32'h12);
        bus_write(8'h04, 3'd4, 32'h77);
        bus_write(8'h14, 3'd4, 32'h9999_9999);
        chk("R10 odd offset no pulse", {63'h0, seen_pulse}, 64'h0);
        bus_read(8'h04, 3'd4, d);
        chk("R10 odd offset reads zero", {32'h0, d}, 64'h0);
        bus_read(8'h00, 3'd4, d);
        chk("R10 select kept", {32'h0, d}, 64'h12);
        chk_table("R10 table unchanged");
    endtask

    task automatic t_rdwr;
        logic [31:0] d;
        bus_write(8'h00, 3'd4, 32'h12);
        @(negedge clk);
        bus_addr = 8'h10; bus_size = 3'd4; bus_wdata = 32'h1234_5678;
        bus_rd = 1'b1; bus_wr = 1'b1;
        @(negedge clk);
        chk("R11 read performed", {32'h0, bus_rdata}, {32'h0, exp_ent[1][31:0]});
        chk("R11 no pulse", {63'h0, upd_pulse}, 64'h0);
        bus_rd = 1'b0; bus_wr = 1'b0;
        chk_table("R11 write dropped");
        bus_read(8'h10, 3'd4, d);
        chk("R11 entry intact", {32'h0, d}, {32'h0, exp_ent[1][31:0]});
    endtask

    initial begin
        for (int k = 0; k < PINS; k++) exp_ent[k] = RST_ENT;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_select();
        t_id_ver();
        t_table();
        t_narrow();
        t_range();
        t_decode();
        t_rdwr();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #400000;
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule